// File: doc/BRIEF.md
# FP Compare and Condition-Flag Branch Unit

This unit handles the compare and branch-on-flag instructions of a floating-point coprocessor. A compare instruction looks at two single-precision register values and writes a one-bit condition flag: the flag is set when the selected relation holds and cleared when it does not. A later branch instruction reads that flag. The unit tells the fetch logic in the same cycle whether the branch is taken, and it supplies the sign-extended branch offset.

The register file sits outside the unit. Its two read ports feed the operands `opA` (the fs register) and `opB` (the ft register). A one-cycle strobe marks the instruction word as valid. The flag is held in a register, so a branch issued in the cycle right after a compare sees the new value. A compare that names the double format is reported as illegal and leaves the flag as it was. Every other instruction word passes through with no effect.

Top module: `fcmp_branch_unit`

## Requirements
- R1: After reset, `condFlag` is 0.
- R2: An equal compare writes the flag on the next rising edge. It is a valid word with opcode 17 in bits 31:26, format 0 (single) in bits 25:21 and function 50 in bits 5:0. The flag becomes 1 when `opA` equals `opB` and 0 otherwise.
- R3: A less-than compare (function 60, format 0, opcode 17) sets the flag when `opA` < `opB` and clears it otherwise.
- R4: A less-or-equal compare (function 62, format 0, opcode 17) sets the flag when `opA` <= `opB` and clears it otherwise.
- R5: If either operand is a NaN, every compare clears the flag. A NaN has exponent bits 30:23 all ones and a nonzero fraction in bits 22:0.
- R6: +0 and -0 compare equal. Neither is less than the other.
- R7: A valid compare word with format 1 (double) in bits 25:21 raises `illegalInstr` in the same cycle and leaves the flag unchanged. No other word raises `illegalInstr`.
- R8: A branch is a valid word with opcode 17 and the value 8 in bits 25:21. Bit 16 gives its sense (1 = branch if the flag is true, 0 = branch if it is false). `branchTaken` is high in that same cycle exactly when the flag equals the sense bit.
- R9: `branchTaken` is low in any cycle without both the valid strobe and a branch decode.
- R10: `branchOffset` is bits 15:0 of the instruction word, sign-extended to the output width.
- R11: A branch in the cycle right after a compare uses the flag value that the compare wrote.
- R12: A word with another opcode, another function code, or the valid strobe low leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | The instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| opA | input | 32 | Single-precision value of the fs register |
| opB | input | 32 | Single-precision value of the ft register |
| condFlag | output | 1 | FP condition flag register |
| branchTaken | output | 1 | The branch-on-flag is taken this cycle |
| illegalInstr | output | 1 | Double-format compare detected |
| branchOffset | output | 32 | Sign-extended branch offset |

## Verification
The bench drives compares with operand pairs that catch the usual ordering mistakes:
- Two negatives. A design that compares raw magnitudes reports the wrong order.
- Opposite signs.
- Signed zeros. A design that compares bit patterns would call +0 and -0 unequal, or order -0 below +0.
- Infinities.
- NaNs, set up so the flag starts at 1. A design that ignores NaN would leave the flag set.

A double-format compare is sent while the flag holds 1. A design that decodes too loosely would write the flag or miss the illegal report. Every compare is followed at once by a branch of each sense, which exposes a taken signal that reads a stale flag or inverts the sense bit. Negative and positive offsets and non-coprocessor words with compare function codes round out the stimulus.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int INSTR_W   = 32;
  localparam int OPC_LSB   = 26;
  localparam int FMT_LSB   = 21;
  localparam int FMT_W     = 5;
  localparam int FN_W      = 6;
  localparam int SENSE_BIT = 16;

  localparam logic [5:0]       OPC_COP1   = 6'd17;
  localparam logic [FMT_W-1:0] FMT_SINGLE = 5'd0;
  localparam logic [FMT_W-1:0] FMT_DOUBLE = 5'd1;
  localparam logic [FMT_W-1:0] FMT_BRANCH = 5'd8;
  localparam logic [FN_W-1:0]  FN_EQ      = 6'd50;
  localparam logic [FN_W-1:0]  FN_LT      = 6'd60;
  localparam logic [FN_W-1:0]  FN_LE      = 6'd62;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_LE = 2'd2
  } relSel_e;

  typedef struct packed {
    logic    cmpWrite;
    logic    branchEval;
    logic    branchOnTrue;
    logic    illegal;
    relSel_e relSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobes_t       ctrl
);
  logic [5:0]       opcode;
  logic [FMT_W-1:0] fmtField;
  logic [FN_W-1:0]  fnField;
  logic             isCop1;
  logic             isCmpFn;
  relSel_e          relSel;

  assign opcode   = instrWord[INSTR_W-1:OPC_LSB];
  assign fmtField = instrWord[FMT_LSB+FMT_W-1:FMT_LSB];
  assign fnField  = instrWord[FN_W-1:0];
  assign isCop1   = instrValid && (opcode == OPC_COP1);

  always_comb begin
    isCmpFn = 1'b1;
    relSel  = REL_EQ;
    unique case (fnField)
      FN_EQ:   relSel = REL_EQ;
      FN_LT:   relSel = REL_LT;
      FN_LE:   relSel = REL_LE;
      default: isCmpFn = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.cmpWrite     = isCop1 && isCmpFn && (fmtField == FMT_SINGLE);
    ctrl.illegal      = isCop1 && isCmpFn && (fmtField == FMT_DOUBLE);
    ctrl.branchEval   = isCop1 && (fmtField == FMT_BRANCH);
    ctrl.branchOnTrue = instrWord[SENSE_BIT];
    ctrl.relSel       = relSel;
  end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  relSel_e              relSel,
  output logic                 relHolds
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int MAG_W = FP_W - 1;

  logic             signA, signB;
  logic [MAG_W-1:0] magA, magB;
  logic             nanA, nanB, anyNan, bothZero;
  logic             eqRel, ltRel;

  assign signA = opA[FP_W-1];
  assign signB = opB[FP_W-1];
  assign magA  = opA[MAG_W-1:0];
  assign magB  = opB[MAG_W-1:0];
  assign nanA  = (&opA[MAG_W-1:MAN_W]) && (|opA[MAN_W-1:0]);
  assign nanB  = (&opB[MAG_W-1:MAN_W]) && (|opB[MAN_W-1:0]);
  assign anyNan   = nanA || nanB;
  assign bothZero = (magA == '0) && (magB == '0);

  always_comb begin
    eqRel = !anyNan && (bothZero || (opA == opB));
    if (anyNan || bothZero)   ltRel = 1'b0;
    else if (signA != signB)  ltRel = signA;
    else if (signA)           ltRel = magA > magB;
    else                      ltRel = magA < magB;
  end

  always_comb begin
    unique case (relSel)
      REL_LT:  relHolds = ltRel;
      REL_LE:  relHolds = ltRel || eqRel;
      default: relHolds = eqRel;
    endcase
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         ctrl,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic [OFF_W-1:0]     offsetField,
  output logic                 condFlag,
  output logic                 branchTaken,
  output logic [ADDR_W-1:0]    branchOffset
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic relHolds;

  fcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .opA     (opA),
    .opB     (opB),
    .relSel  (ctrl.relSel),
    .relHolds(relHolds)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              condFlag <= 1'b0;
    else if (ctrl.cmpWrite) condFlag <= relHolds;
  end

  assign branchTaken  = ctrl.branchEval && (condFlag == ctrl.branchOnTrue);
  assign branchOffset = {{EXT_W{offsetField[OFF_W-1]}}, offsetField};
endmodule

// File: rtl/fcmp_branch_unit.sv
module fcmp_branch_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instrValid,
  input  logic [INSTR_W-1:0]        instrWord,
  input  logic [EXP_W+MAN_W:0]      opA,
  input  logic [EXP_W+MAN_W:0]      opB,
  output logic                      condFlag,
  output logic                      branchTaken,
  output logic                      illegalInstr,
  output logic [ADDR_W-1:0]         branchOffset
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  ctrlStrobes_t ctrl;

  fcmp_ctrl u_ctrl (
    .instrValid(instrValid),
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .opA         (opA),
    .opB         (opB),
    .offsetField (instrWord[OFF_W-1:0]),
    .condFlag    (condFlag),
    .branchTaken (branchTaken),
    .branchOffset(branchOffset)
  );

  assign illegalInstr = ctrl.illegal;
endmodule

// File: rtl/fcmp_branch_unit_chk.sv
module fcmp_branch_unit_chk #(
  parameter int FP_W   = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [31:0]       instrWord,
  input logic [FP_W-1:0]   opA,
  input logic [FP_W-1:0]   opB,
  input logic              condFlag,
  input logic              branchTaken,
  input logic              illegalInstr,
  input logic [ADDR_W-1:0] branchOffset
);
  logic cop1, cmpFn, singleCmp, brDecode, anyNan, bothZero;
  assign cop1      = instrValid && (instrWord[31:26] == 6'd17);
  assign cmpFn     = (instrWord[5:0] == 6'd50) || (instrWord[5:0] == 6'd60) ||
                     (instrWord[5:0] == 6'd62);
  assign singleCmp = cop1 && cmpFn && (instrWord[25:21] == 5'd0);
  assign brDecode  = cop1 && (instrWord[25:21] == 5'd8);
  assign anyNan    = ((&opA[30:23]) && (|opA[22:0])) || ((&opB[30:23]) && (|opB[22:0]));
  assign bothZero  = (opA[30:0] == '0) && (opB[30:0] == '0);

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> !condFlag);

  // R12 and R7: only a single-format compare may change the flag
  a_r12_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    !singleCmp |=> $stable(condFlag));

  a_r7_illegal_only_double: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> (cop1 && cmpFn && instrWord[25:21] == 5'd1));

  a_r5_nan_false: assert property (@(posedge clk) disable iff (!rstN)
    (singleCmp && anyNan) |=> !condFlag);

  a_r6_zero_equal: assert property (@(posedge clk) disable iff (!rstN)
    (singleCmp && bothZero && instrWord[5:0] != 6'd60) |=> condFlag);

  a_r9_taken_needs_branch: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> brDecode);

  a_r8_sense_match: assert property (@(posedge clk) disable iff (!rstN)
    (brDecode && condFlag == instrWord[16]) |-> branchTaken);
endmodule

bind fcmp_branch_unit fcmp_branch_unit_chk #(.FP_W(FP_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fcmp_branch_unit_bench.sv
module fcmp_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        condFlag, branchTaken, illegalInstr;
  logic [31:0] branchOffset;

  int checks = 0;
  int errors = 0;
  logic modelFlag = 1'b0;

  typedef struct {
    logic        expFlag;
    logic        expTaken;
    logic        expIllegal;
    logic [31:0] expOffset;
    string       tag;
  } item_t;
  item_t sb[$];

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] N2 = 32'hC000_0000, N3 = 32'hC040_0000, PZ = 32'h0000_0000;
  localparam logic [31:0] NZ = 32'h8000_0000, PINF = 32'h7F80_0000, QNAN = 32'h7FC0_0000;

  always #4 clk = ~clk;

  fcmp_branch_unit u_fcmp_branch_unit (.*);

  function automatic logic isNan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic [31:0] orderKey(logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction
  function automatic logic [31:0] cmpWord(logic [4:0] fmt, logic [5:0] fn);
    return {6'd17, fmt, 5'd3, 5'd7, 5'd0, fn};
  endfunction
  function automatic logic [31:0] brWord(logic sense, logic [15:0] off);
    return {6'd17, 5'd8, 4'd0, sense, off};
  endfunction

  task automatic check(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, string tag, logic v = 1'b1);
    item_t it;
    logic op17, isCmp, rel;
    @(negedge clk);
    instrValid = v; instrWord = w; opA = a; opB = b;
    op17  = v && (w[31:26] == 6'd17);
    isCmp = (w[5:0] == 6'd50) || (w[5:0] == 6'd60) || (w[5:0] == 6'd62);
    it.expFlag    = modelFlag;
    it.expTaken   = op17 && (w[25:21] == 5'd8) && (modelFlag == w[16]);
    it.expIllegal = op17 && isCmp && (w[25:21] == 5'd1);
    it.expOffset  = {{16{w[15]}}, w[15:0]};
    it.tag        = tag;
    sb.push_back(it);
    if (op17 && isCmp && w[25:21] == 5'd0) begin
      if (isNan(a) || isNan(b)) rel = 1'b0;
      else if (w[5:0] == 6'd50) rel = orderKey(a) == orderKey(b);
      else if (w[5:0] == 6'd60) rel = orderKey(a) <  orderKey(b);
      else                      rel = orderKey(a) <= orderKey(b);
      modelFlag = rel;
    end
  endtask

  // monitor: outputs settle shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(condFlag == it.expFlag, it.tag, "condFlag", {31'd0, condFlag}, {31'd0, it.expFlag});
        check(branchTaken == it.expTaken, it.tag, "branchTaken", {31'd0, branchTaken}, {31'd0, it.expTaken});
        check(illegalInstr == it.expIllegal, it.tag, "illegalInstr", {31'd0, illegalInstr}, {31'd0, it.expIllegal});
        check(branchOffset == it.expOffset, "R10", "branchOffset", branchOffset, it.expOffset);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    issue(32'h0, PZ, PZ, "R1", 1'b0);                     // reset flag 0
    issue(brWord(1'b1, 16'h0004), P1, P1, "R9", 1'b0);    // no valid: not taken
    issue(brWord(1'b0, 16'h0008), P1, P1, "R8");          // flag 0, branch-false taken
    issue(cmpWord(5'd0, 6'd50), P1, P1, "R2");            // eq true
    issue(brWord(1'b1, 16'h0010), PZ, PZ, "R11");         // sees new flag
    issue(brWord(1'b0, 16'hFFF0), PZ, PZ, "R8");          // not taken, negative offset
    issue(cmpWord(5'd0, 6'd50), P1, P2, "R2");
    issue(brWord(1'b0, 16'h8000), PZ, PZ, "R11");
    issue(cmpWord(5'd0, 6'd60), P1, P2, "R3");
    issue(cmpWord(5'd0, 6'd60), P2, P1, "R3");
    issue(cmpWord(5'd0, 6'd60), N3, N2, "R3");
    issue(cmpWord(5'd0, 6'd60), N2, N3, "R3");
    issue(cmpWord(5'd0, 6'd60), N1, P1, "R3");
    issue(cmpWord(5'd0, 6'd60), P1, PINF, "R3");
    issue(cmpWord(5'd0, 6'd62), P2, P2, "R4");
    issue(cmpWord(5'd0, 6'd62), P2, P1, "R4");
    issue(cmpWord(5'd0, 6'd62), N2, N1, "R4");
    issue(cmpWord(5'd0, 6'd50), P1, P1, "R5");            // preset flag 1
    issue(cmpWord(5'd0, 6'd50), QNAN, QNAN, "R5");
    issue(cmpWord(5'd0, 6'd62), P1, P1, "R5");
    issue(cmpWord(5'd0, 6'd60), QNAN, P2, "R5");
    issue(cmpWord(5'd0, 6'd62), P1, P1, "R5");
    issue(cmpWord(5'd0, 6'd62), P1, QNAN, "R5");
    issue(cmpWord(5'd0, 6'd50), PZ, NZ, "R6");
    issue(cmpWord(5'd0, 6'd60), NZ, PZ, "R6");
    issue(cmpWord(5'd0, 6'd62), NZ, PZ, "R6");
    issue(cmpWord(5'd1, 6'd50), P1, P2, "R7");            // double: illegal, flag stays 1
    issue(cmpWord(5'd1, 6'd60), P2, P1, "R7");
    issue(brWord(1'b1, 16'h7FFF), PZ, PZ, "R7");
    issue({6'd0, 20'h12345, 6'd50}, P1, P2, "R12");       // other opcode
    issue(cmpWord(5'd0, 6'd0), P1, P2, "R12");            // other function
    issue(cmpWord(5'd0, 6'd50), P1, P2, "R12", 1'b0);     // strobe low
    issue(brWord(1'b1, 16'h1234), PZ, PZ, "R12");
    issue(32'h0, PZ, PZ, "R9");
    issue(32'h0, PZ, PZ, "R9", 1'b0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule